// File: doc/BRIEF.md
# Serial Flash Page-Program Receiver

This block sits behind the pins of a serial flash device and turns the two page-program commands into a request for the array backend. It runs on the system clock and oversamples the chip-select, serial clock and two data pins through a synchronizer. A rising serial clock while chip select is low is a sample point, so both idle-low (mode 0) and idle-high (mode 3) hosts work. After the 8-bit opcode it takes a 24-bit start address, then fills a page buffer with data bytes that arrive either one bit per clock on the input pin or two bits per clock on both pins.

The low address byte is a column pointer that wraps inside the page, so a long burst keeps only the most recent page-worth of bytes. Each buffer column has a valid bit so that the backend programs only the columns that were written. When chip select rises after at least one whole data byte, the block pulses a request carrying the page number and the input mode, and it clears its write-enable latch. The backend reads the buffer and the valid bits through a combinational read port.

Top module: `page_prog_rx`

## Requirements
- R1: Inputs are sampled on the rising serial clock while chip select is low, whether the clock idles low or high between commands.
- R2: Opcode 8'h02 selects single-bit input and opcode 8'hA2 selects dual-bit input; any other opcode is ignored for the rest of the command: no request, write-enable latch and buffer unchanged.
- R3: After either opcode, 24 address bits are taken MSB first from the input pin, one per clock; the request reports address bits 23..8 as the page.
- R4: In dual mode each clock delivers two data bits, the higher on the output pin and the lower on the input pin, so a byte takes four clocks in the order 7/6, 5/4, 3/2, 1/0.
- R5: In single mode a data byte takes eight clocks on the input pin, MSB first.
- R6: The write-enable latch is set by a one-cycle pulse on `welSet`; a program opcode that completes while it is clear is ignored: no request and buffer unchanged.
- R7: Bytes go to consecutive columns from address bits 7..0; after column 8'hFF the next byte goes to column 8'h00 of the same page.
- R8: When more than 256 bytes are sent, each column holds the last byte written to it.
- R9: A completed command raises `reqValid` for exactly one cycle within 8 clock cycles of chip select rising, with `reqDual` giving the mode, and the write-enable latch reads 0 from that cycle on.
- R10: If chip select rises before the address is complete, or before the first whole data byte, no request is issued and the latch stays set; bits of a trailing partial byte are never written.
- R11: All column valid bits clear when an accepted command's address completes; each written column's valid bit then reads 1 on `rdVld`, with its byte on `rdByte`.
- R12: After reset the latch is 0, `reqValid` is 0 and every column's valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select pin, active low |
| sckIn | input | 1 | Serial clock pin |
| siIn | input | 1 | Serial input pin |
| soIn | input | 1 | Value on the serial output pin, used as the high data bit in dual mode |
| welSet | input | 1 | One-cycle pulse that sets the write-enable latch |
| welState | output | 1 | Current write-enable latch value |
| reqValid | output | 1 | One-cycle program request pulse |
| reqDual | output | 1 | Mode of the last accepted command, 1 for dual input |
| reqPage | output | 16 | Page number, address bits 23..8 |
| rdCol | input | 8 | Buffer column to read |
| rdByte | output | 8 | Buffer byte at `rdCol` |
| rdVld | output | 1 | Valid bit of column `rdCol` |

## Verification
A bit counter that slips by one clock shows at the ports as every byte of the command shifted by one bit, so the buffer readback after the first command with data already disagrees. A wrong column pointer shows as bytes in the wrong columns or missing valid bits at the readback after that command, and the wrap and overflow cases expose a pointer that does not wrap. A write-enable latch that is not cleared or not checked shows as a second request from a command sent without a new enable pulse, seen within the 20-cycle window after that chip select rises.

// File: rtl/page_prog_pkg.sv
package page_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rxState_e;

  typedef struct packed {
    logic shiftOne;     // shift one bit from the input pin
    logic shiftTwo;     // shift two bits, output pin above input pin
    logic captureAddr;  // latch page and column, clear valid bits
    logic writeByte;    // store assembled byte at the column pointer
  } dpStrobe_t;

endpackage

// File: rtl/page_prog_sync.sv
module page_prog_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= {STAGES{RST_VAL}};
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl
  import page_prog_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [7:0] OPC_SINGLE = 8'h02,
  parameter logic [7:0] OPC_DUAL = 8'hA2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sckS,
  input  logic [7:0] srByte,
  input  logic       welSet,
  output dpStrobe_t  strobe,
  output logic       welState,
  output logic       reqValid,
  output logic       reqDual
);

  localparam int DATA_W = 8;
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] SINGLE_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] DUAL_LAST = CNT_W'(DATA_W / 2 - 1);

  rxState_e stateQ;
  logic [CNT_W-1:0] bitCntQ;
  logic sckPrevQ, csPrevQ;
  logic dualQ, haveByteQ, welQ, reqValidQ;

  logic sckRise, csRise, csFall, edgeOk, opcodeHit;
  logic [CNT_W-1:0] byteLast;

  assign sckRise = sckS & ~sckPrevQ;
  assign csRise = csS & ~csPrevQ;
  assign csFall = ~csS & csPrevQ;
  assign edgeOk = sckRise & ~csS;
  assign byteLast = dualQ ? DUAL_LAST : SINGLE_LAST;
  assign opcodeHit = (srByte == OPC_SINGLE) || (srByte == OPC_DUAL);

  always_comb begin
    strobe = '0;
    if (edgeOk) begin
      strobe.shiftOne = (stateQ == ST_OPC) || (stateQ == ST_ADDR) ||
                        ((stateQ == ST_DATA) && !dualQ);
      strobe.shiftTwo = (stateQ == ST_DATA) && dualQ;
      strobe.captureAddr = (stateQ == ST_ADDR) && (bitCntQ == ADDR_LAST);
      strobe.writeByte = (stateQ == ST_DATA) && (bitCntQ == byteLast);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      bitCntQ <= '0;
      sckPrevQ <= 1'b0;
      csPrevQ <= 1'b1;
      dualQ <= 1'b0;
      haveByteQ <= 1'b0;
      welQ <= 1'b0;
      reqValidQ <= 1'b0;
    end else begin
      sckPrevQ <= sckS;
      csPrevQ <= csS;
      reqValidQ <= 1'b0;
      if (welSet) welQ <= 1'b1;
      if (csRise) begin
        if (stateQ == ST_DATA && haveByteQ) begin
          reqValidQ <= 1'b1;
          welQ <= 1'b0;
        end
        stateQ <= ST_IDLE;
      end else if (csFall) begin
        stateQ <= ST_OPC;
        bitCntQ <= '0;
        haveByteQ <= 1'b0;
      end else if (edgeOk) begin
        case (stateQ)
          ST_OPC: begin
            if (bitCntQ == OPC_LAST) begin
              bitCntQ <= '0;
              if (opcodeHit && welQ) begin
                stateQ <= ST_ADDR;
                dualQ <= (srByte == OPC_DUAL);
              end else begin
                stateQ <= ST_SKIP;
              end
            end else begin
              bitCntQ <= bitCntQ + 1'b1;
            end
          end
          ST_ADDR: begin
            if (bitCntQ == ADDR_LAST) begin
              bitCntQ <= '0;
              stateQ <= ST_DATA;
            end else begin
              bitCntQ <= bitCntQ + 1'b1;
            end
          end
          ST_DATA: begin
            if (bitCntQ == byteLast) begin
              bitCntQ <= '0;
              haveByteQ <= 1'b1;
            end else begin
              bitCntQ <= bitCntQ + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign welState = welQ;
  assign reqValid = reqValidQ;
  assign reqDual = dualQ;

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValidQ |=> !reqValidQ);
  assert_req_clears_wel_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValidQ |-> !welQ);
  assert_req_had_wel_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValidQ |-> $past(welQ));
  assert_req_had_byte_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValidQ |-> $past(haveByteQ));

endmodule

// File: rtl/page_prog_dp.sv
module page_prog_dp
  import page_prog_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strobe,
  input  logic                          siBit,
  input  logic                          soBit,
  input  logic [$clog2(PAGE_BYTES)-1:0] rdCol,
  output logic [7:0]                    srByte,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] reqPage,
  output logic [7:0]                    rdByte,
  output logic                          rdVld
);

  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;

  logic [ADDR_W-1:0] srQ, srNext;
  logic [COL_W-1:0] colQ;
  logic [PAGE_W-1:0] pageQ;
  logic [PAGE_BYTES-1:0] vldQ;
  logic [7:0] memQ [PAGE_BYTES];

  always_comb begin
    srNext = srQ;
    if (strobe.shiftOne) srNext = {srQ[ADDR_W-2:0], siBit};
    else if (strobe.shiftTwo) srNext = {srQ[ADDR_W-3:0], soBit, siBit};
  end

  assign srByte = srNext[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srQ <= '0;
      colQ <= '0;
      pageQ <= '0;
      vldQ <= '0;
    end else begin
      srQ <= srNext;
      if (strobe.captureAddr) begin
        pageQ <= srNext[ADDR_W-1:COL_W];
        colQ <= srNext[COL_W-1:0];
        vldQ <= '0;
      end else if (strobe.writeByte) begin
        vldQ[colQ] <= 1'b1;
        colQ <= colQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeByte) memQ[colQ] <= srNext[7:0];
  end

  assign reqPage = pageQ;
  assign rdByte = memQ[rdCol];
  assign rdVld = vldQ[rdCol];

  assert_col_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeByte && colQ == '1) |=> colQ == '0);
  assert_vld_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeByte |=> vldQ[$past(colQ)]);
  assert_addr_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureAddr |=> vldQ == '0);
  assert_dual_pins_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftTwo |=> srQ[1:0] == $past({soBit, siBit}));

endmodule

// File: rtl/page_prog_rx.sv
module page_prog_rx
  import page_prog_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_BYTES = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sckIn,
  input  logic        siIn,
  input  logic        soIn,
  input  logic        welSet,
  output logic        welState,
  output logic        reqValid,
  output logic        reqDual,
  output logic [15:0] reqPage,
  input  logic [7:0]  rdCol,
  output logic [7:0]  rdByte,
  output logic        rdVld
);

  logic [3:0] pinsS;
  logic [7:0] srByte;
  dpStrobe_t strobe;

  page_prog_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) uSync (
    .clk(clk), .rstN(rstN), .din({csN, sckIn, siIn, soIn}), .dout(pinsS)
  );

  page_prog_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csS(pinsS[3]), .sckS(pinsS[2]), .srByte(srByte),
    .welSet(welSet), .strobe(strobe), .welState(welState),
    .reqValid(reqValid), .reqDual(reqDual)
  );

  page_prog_dp #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .siBit(pinsS[1]), .soBit(pinsS[0]),
    .rdCol(rdCol), .srByte(srByte), .reqPage(reqPage), .rdByte(rdByte), .rdVld(rdVld)
  );

endmodule

// File: tb/tb_page_prog_rx.sv
`timescale 1ns/1ps
module tb_page_prog_rx;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, so = 1'b0, welSet = 1'b0;
  logic [7:0] rdCol = '0;
  logic welState, reqValid, reqDual, rdVld;
  logic [15:0] reqPage;
  logic [7:0] rdByte;

  int checkCnt = 0, failCnt = 0, reqCount = 0;
  logic [15:0] lastPage;
  logic lastDual;
  bit done = 0;

  logic [7:0] txBytes [300];
  logic [7:0] modelMem [256];
  bit modelVld [256];
  bit modelWel = 0;

  always #2.5 clk = ~clk;

  page_prog_rx dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sckIn(sck), .siIn(si), .soIn(so),
    .welSet(welSet), .welState(welState), .reqValid(reqValid), .reqDual(reqDual),
    .reqPage(reqPage), .rdCol(rdCol), .rdByte(rdByte), .rdVld(rdVld)
  );

  always @(negedge clk) begin
    if (reqValid) begin
      reqCount <= reqCount + 1;
      lastPage <= reqPage;
      lastDual <= reqDual;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pulseWel();
    @(negedge clk) welSet = 1'b1;
    @(negedge clk) welSet = 1'b0;
    modelWel = 1;
  endtask

  task automatic clkBit(input logic siV, input logic soV);
    @(negedge clk);
    sck = 1'b0; si = siV; so = soV;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic compareBuffer(input string tag);
    int bad = 0;
    int firstCol = -1;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk) rdCol = 8'(c);
      #1;
      if (rdVld !== modelVld[c] || (modelVld[c] && rdByte !== modelMem[c])) begin
        bad++;
        if (firstCol < 0) firstCol = c;
      end
    end
    check(bad == 0, tag, "buffer columns wrong (count/first)", bad, firstCol);
  endtask

  // cutClk < 0 means the command runs to its natural end
  task automatic runCmd(input bit m3, input logic [7:0] opc, input logic [23:0] addr,
                        input int nBytes, input int tailClk, input int cutClk,
                        input string tag);
    bit isDual = (opc == 8'hA2);
    int perByte = isDual ? 4 : 8;
    int total = 32 + nBytes * perByte + tailClk;
    int startCnt;
    bit accepted, expReq;
    int fullBytes;
    logic [7:0] col;
    if (cutClk >= 0 && cutClk < total) total = cutClk;
    // model
    accepted = ((opc == 8'h02) || (opc == 8'hA2)) && modelWel && (total >= 8);
    expReq = 0;
    if (accepted && total >= 32) begin
      for (int c = 0; c < 256; c++) modelVld[c] = 0;
      fullBytes = (total - 32) / perByte;
      if (fullBytes > nBytes) fullBytes = nBytes;
      col = addr[7:0];
      for (int i = 0; i < fullBytes; i++) begin
        modelMem[col] = txBytes[i];
        modelVld[col] = 1;
        col = col + 8'd1;
      end
      expReq = (fullBytes >= 1);
      if (expReq) modelWel = 0;
    end
    // stimulus
    startCnt = reqCount;
    @(negedge clk) sck = m3;
    repeat (HALF) @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < total; k++) begin
      if (k < 8) clkBit(opc[7-k], 1'b0);
      else if (k < 32) clkBit(addr[31-k], 1'b0);
      else begin
        int d = k - 32;
        int bi = d / perByte;
        int pos = d % perByte;
        logic [7:0] b = (bi < 300) ? txBytes[bi] : 8'h00;
        if (isDual) clkBit(b[6-2*pos], b[7-2*pos]);
        else clkBit(b[7-pos], 1'b0);
      end
    end
    if (!m3) sck = 1'b0;
    repeat (HALF) @(negedge clk);
    csN = 1'b1; so = 1'b0;
    repeat (20) @(negedge clk);
    // checks
    check((reqCount - startCnt) == int'(expReq), tag, "request count",
          reqCount - startCnt, int'(expReq));
    if (expReq) begin
      check(lastPage == addr[23:8], tag, "request page (R3)", lastPage, addr[23:8]);
      check(lastDual == isDual, tag, "request mode", lastDual, isDual);
    end
    check(welState == modelWel, tag, "write-enable latch", welState, modelWel);
    compareBuffer(tag);
  endtask

  task automatic fillTx();
    for (int i = 0; i < 300; i++) txBytes[i] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int c = 0; c < 256; c++) begin modelVld[c] = 0; modelMem[c] = 8'h00; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    // R12: reset state
    check(welState == 1'b0, "R12", "latch after reset", welState, 0);
    check(reqCount == 0, "R12", "no request after reset", reqCount, 0);
    compareBuffer("R12");

    // R7, R5, R1 (mode 0): wrap from FE
    fillTx(); pulseWel();
    runCmd(1'b0, 8'h02, 24'h0000FE, 3, 0, -1, "R7");
    // R4 (mode 3 dual)
    fillTx(); pulseWel();
    runCmd(1'b1, 8'hA2, 24'h012340, 5, 0, -1, "R4");
    // R6: latch clear, command ignored
    fillTx();
    runCmd(1'b0, 8'h02, 24'h022200, 4, 0, -1, "R6");
    // R2: unknown opcode ignored, latch kept
    fillTx(); pulseWel();
    runCmd(1'b1, 8'h03, 24'h033300, 4, 0, -1, "R2");
    // R8: overflow in dual mode
    fillTx();
    runCmd(1'b0, 8'hA2, 24'h07FF10, 260, 0, -1, "R8");
    // R10: abort mid-address
    fillTx(); pulseWel();
    runCmd(1'b0, 8'h02, 24'h045600, 4, 0, 20, "R10");
    // R10: address done, only partial byte
    runCmd(1'b1, 8'h02, 24'h045680, 0, 5, -1, "R10");
    // R10: two bytes plus a partial trailing byte
    fillTx();
    runCmd(1'b0, 8'h02, 24'h0456F0, 2, 7, -1, "R10");
    // R1 / R3: mode 3 single, one byte
    fillTx(); pulseWel();
    runCmd(1'b1, 8'h02, 24'h5A3C77, 1, 0, -1, "R1");
    // R11: dual command with partial trailing clocks
    fillTx(); pulseWel();
    runCmd(1'b1, 8'hA2, 24'h00A0FF, 6, 3, -1, "R11");

    // R9: random mix
    for (int n = 0; n < 20; n++) begin
      bit m3 = 1'($urandom);
      bit dl = 1'($urandom);
      int len = 1 + ($urandom % 24);
      logic [23:0] a = 24'($urandom);
      fillTx();
      if (($urandom % 5) != 0) pulseWel();
      runCmd(m3, dl ? 8'hA2 : 8'h02, a, len, 0, -1, "R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule